// File: doc/BRIEF.md
# Four-channel DMA register file

The block is the register interface that software sees on a four-channel DMA controller. A 4-bit port index and an 8-bit data bus reach it through one-cycle read and write strobes. The channel engines and the arbiter read the programmed values from its outputs: the base address, the base count, the mode fields of each channel, the channel masks, the software requests and the command byte. The engines return the current address, the current count, terminal-count pulses and hardware requests. The block uses these to answer reads of the address, count and status ports.

Every channel register is 16 bits wide and has a single byte port. Each address or count port moves one byte per access, and one shared pointer bit chooses whether that byte is the low or the high half. Several command ports act on the strobe alone and ignore the data. These are the pointer clear, the master reset and the all-channel unmask. The terminal-count flags are sticky, and a read of the status port clears them.

Top module: `dma_regfile`

## Requirements
- R1: Index 2n is the address port of channel n and index 2n+1 is its count port (n = 0..3). A write stores the byte in the base register of that channel: in bits 7:0 when the byte pointer is low, in bits 15:8 when it is high.
- R2: The byte pointer starts low and flips after every read or write of indices 0..7. An access to indices 8..15 leaves it unchanged.
- R3: A write to index 12 forces the byte pointer low, whatever the data.
- R4: A read of an address or count port returns one byte of that channel's current address or current count (cur_addr_i / cur_cnt_i), low byte when the pointer is low. Writes go only to the base registers and leave the current values alone.
- R5: A write to index 13, whatever the data, does the following: it sets all four mask bits, clears the command byte, the software requests, the terminal-count flags and every channel's mode fields, and forces the byte pointer low.
- R6: A write to index 14, whatever the data, clears all four mask bits.
- R7: A write to index 10 picks a channel with data bits 1:0. Bit 2 then sets (1) or clears (0) that channel's mask, and the other masks keep their values.
- R8: A write to index 15 loads mask bit n from data bit n (n = 0..3), where 1 disables the channel.
- R9: A write to index 11 picks a channel with data bits 1:0 and loads that channel's mode fields: bits 3:2 give the transfer type, bit 4 auto-init, bit 5 address decrement, and bits 7:6 the mode (0 demand, 1 single, 2 block, 3 cascade). The other channels keep their mode fields.
- R10: A read of index 8 returns the request-pending flags in bits 7:4 and the terminal-count flags in bits 3:0, with bit 4+n and bit n belonging to channel n. A request is pending when drq_i[n] or the software request of channel n is set.
- R11: A pulse on tc_i[n] sets the terminal-count flag of channel n until the next status read. A pulse that arrives in the same cycle as a status read is not shown by that read and stays set afterwards.
- R12: A write to index 9 picks a channel with data bits 1:0 and sets (bit 2 = 1) or clears (bit 2 = 0) its software request. A write to index 8 loads the command byte.
- R13: After reset all mask bits are set, and the command byte, software requests, flags, mode fields and base registers are zero. Reads of write-only indices (9..15) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | 4 | Port index |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| cur_addr_i | input | 64 | Current address of each channel, 16 bits per channel |
| cur_cnt_i | input | 64 | Current count of each channel, 16 bits per channel |
| tc_i | input | 4 | Terminal-count pulse of each channel |
| drq_i | input | 4 | Hardware request of each channel |
| base_addr_o | output | 64 | Base address of each channel |
| base_cnt_o | output | 64 | Base count of each channel |
| xfer_type_o | output | 8 | Transfer type of each channel, 2 bits per channel |
| auto_init_o | output | 4 | Auto-init enable of each channel |
| addr_dec_o | output | 4 | Address decrement of each channel |
| xfer_mode_o | output | 8 | Transfer mode of each channel, 2 bits per channel |
| mask_o | output | 4 | Channel mask bits, 1 = disabled |
| sw_req_o | output | 4 | Software request of each channel |
| cmd_o | output | 8 | Command byte |

## Verification
A byte pointer in the wrong state does not show up right away. Its effect appears on the next access to a channel port, as a base register with its two bytes swapped or merged, or as a read that returns the wrong half. For that reason the bench reads back base_addr_o and base_cnt_o after byte writes that are interleaved with command-port accesses and with pointer clears. A terminal-count flag that is lost or not cleared appears at the second status read. A bad mask or mode decode appears on mask_o or on the mode outputs in the cycle after the write.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;
  typedef enum logic [1:0] {
    XM_DEMAND  = 2'd0,
    XM_SINGLE  = 2'd1,
    XM_BLOCK   = 2'd2,
    XM_CASCADE = 2'd3
  } xfer_mode_e;

  // Mirrors data bits 7:2 of a mode write
  typedef struct packed {
    logic [1:0] xmode;
    logic       dec;
    logic       auto_init;
    logic [1:0] xtype;
  } chan_mode_t;

  localparam logic [3:0] IDX_CMD    = 4'd8;
  localparam logic [3:0] IDX_REQ    = 4'd9;
  localparam logic [3:0] IDX_SMASK  = 4'd10;
  localparam logic [3:0] IDX_MODE   = 4'd11;
  localparam logic [3:0] IDX_CLRPTR = 4'd12;
  localparam logic [3:0] IDX_MRST   = 4'd13;
  localparam logic [3:0] IDX_UNMASK = 4'd14;
  localparam logic [3:0] IDX_AMASK  = 4'd15;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  input  logic clear_i,
  output logic hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_o <= 1'b0;
    else if (clear_i)  hi_o <= 1'b0;
    else if (toggle_i) hi_o <= ~hi_o;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regfile_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_addr_i,
  input  logic              wr_cnt_i,
  input  logic              wr_mode_i,
  input  logic              mode_clr_i,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [REG_W-1:0]  base_addr_o,
  output logic [REG_W-1:0]  base_cnt_o,
  output chan_mode_t        mode_o
);
  localparam int HI_W = REG_W - DATA_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_o <= '0;
      base_cnt_o  <= '0;
    end else begin
      if (wr_addr_i) begin
        if (hi_i) base_addr_o[REG_W-1:DATA_W] <= wdata_i[HI_W-1:0];
        else      base_addr_o[DATA_W-1:0]     <= wdata_i;
      end
      if (wr_cnt_i) begin
        if (hi_i) base_cnt_o[REG_W-1:DATA_W] <= wdata_i[HI_W-1:0];
        else      base_cnt_o[DATA_W-1:0]     <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mode_o <= '0;
    else if (mode_clr_i) mode_o <= '0;
    else if (wr_mode_i)  mode_o <= chan_mode_t'(wdata_i[7:2]);
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regfile_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              stat_rd_i,
  input  logic [NUM_CH-1:0] tc_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] req_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic [NUM_CH-1:0] tc_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic mrst;
  logic [CH_W-1:0] sel;
  logic [NUM_CH-1:0] sel_oh;

  assign mrst = wr_i && (idx_i == IDX_MRST);
  assign sel  = wdata_i[CH_W-1:0];

  always_comb begin
    sel_oh = '0;
    for (int c = 0; c < NUM_CH; c++) sel_oh[c] = (sel == CH_W'(c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      req_o  <= '0;
      cmd_o  <= '0;
    end else if (mrst) begin
      mask_o <= '1;
      req_o  <= '0;
      cmd_o  <= '0;
    end else if (wr_i) begin
      unique case (idx_i)
        IDX_CMD:    cmd_o  <= wdata_i;
        IDX_REQ:    req_o  <= wdata_i[2] ? (req_o | sel_oh) : (req_o & ~sel_oh);
        IDX_SMASK:  mask_o <= wdata_i[2] ? (mask_o | sel_oh) : (mask_o & ~sel_oh);
        IDX_UNMASK: mask_o <= '0;
        IDX_AMASK:  mask_o <= wdata_i[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  // New pulses win over the clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tc_o <= '0;
    else if (mrst)      tc_o <= '0;
    else if (stat_rd_i) tc_o <= tc_i;
    else                tc_o <= tc_o | tc_i;
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regfile_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int REG_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [3:0]               idx_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [NUM_CH*REG_W-1:0]  cur_addr_i,
  input  logic [NUM_CH*REG_W-1:0]  cur_cnt_i,
  input  logic [NUM_CH-1:0]        tc_i,
  input  logic [NUM_CH-1:0]        drq_i,
  output logic [NUM_CH*REG_W-1:0]  base_addr_o,
  output logic [NUM_CH*REG_W-1:0]  base_cnt_o,
  output logic [NUM_CH*2-1:0]      xfer_type_o,
  output logic [NUM_CH-1:0]        auto_init_o,
  output logic [NUM_CH-1:0]        addr_dec_o,
  output logic [NUM_CH*2-1:0]      xfer_mode_o,
  output logic [NUM_CH-1:0]        mask_o,
  output logic [NUM_CH-1:0]        sw_req_o,
  output logic [DATA_W-1:0]        cmd_o
);
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int HI_W   = REG_W - DATA_W;
  localparam int NPORTS = 2 * NUM_CH;

  logic chan_port, ptr_hi, ptr_clr, mrst, stat_rd;
  logic [NUM_CH-1:0] tc_q;
  logic [NUM_CH-1:0] wr_mode_ch;

  assign chan_port = ({28'd0, idx_i} < NPORTS);
  assign mrst      = wr_i && (idx_i == IDX_MRST);
  assign ptr_clr   = mrst || (wr_i && (idx_i == IDX_CLRPTR));
  assign stat_rd   = rd_i && (idx_i == IDX_CMD);

  dma_byte_ptr u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .toggle_i ((wr_i || rd_i) && chan_port),
    .clear_i  (ptr_clr),
    .hi_o     (ptr_hi)
  );

  always_comb begin
    for (int c = 0; c < NUM_CH; c++)
      wr_mode_ch[c] = wr_i && (idx_i == IDX_MODE) && (wdata_i[CH_W-1:0] == CH_W'(c));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_mode_t mode;
    dma_chan_regs #(.REG_W(REG_W), .DATA_W(DATA_W)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_addr_i   (wr_i && (idx_i == 4'(2*c))),
      .wr_cnt_i    (wr_i && (idx_i == 4'(2*c+1))),
      .wr_mode_i   (wr_mode_ch[c]),
      .mode_clr_i  (mrst),
      .hi_i        (ptr_hi),
      .wdata_i     (wdata_i),
      .base_addr_o (base_addr_o[c*REG_W +: REG_W]),
      .base_cnt_o  (base_cnt_o[c*REG_W +: REG_W]),
      .mode_o      (mode)
    );
    assign xfer_type_o[2*c +: 2] = mode.xtype;
    assign auto_init_o[c]        = mode.auto_init;
    assign addr_dec_o[c]         = mode.dec;
    assign xfer_mode_o[2*c +: 2] = mode.xmode;
  end

  dma_ctrl_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .idx_i     (idx_i),
    .wdata_i   (wdata_i),
    .stat_rd_i (stat_rd),
    .tc_i      (tc_i),
    .mask_o    (mask_o),
    .req_o     (sw_req_o),
    .cmd_o     (cmd_o),
    .tc_o      (tc_q)
  );

  logic [REG_W-1:0] rd_word;
  logic [DATA_W-1:0] status;

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (idx_i == 4'(2*c))   rd_word = cur_addr_i[c*REG_W +: REG_W];
      if (idx_i == 4'(2*c+1)) rd_word = cur_cnt_i[c*REG_W +: REG_W];
    end
    status = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      status[c]   = tc_q[c];
      status[4+c] = drq_i[c] | sw_req_o[c];
    end
    rdata_o = '0;
    if (rd_i) begin
      if (chan_port)
        rdata_o = ptr_hi ? DATA_W'(rd_word[REG_W-1:DATA_W]) : rd_word[DATA_W-1:0];
      else if (idx_i == IDX_CMD)
        rdata_o = status;
    end
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        idx_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic              ptr_hi,
  input logic [NUM_CH-1:0] tc_i,
  input logic [NUM_CH-1:0] tc_q,
  input logic [NUM_CH-1:0] mask_o,
  input logic [NUM_CH-1:0] sw_req_o,
  input logic [DATA_W-1:0] cmd_o
);
  a_r2_ptr_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && idx_i < 4'd8) |=> ptr_hi != $past(ptr_hi));

  a_r2_ptr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !rd_i) |=> $stable(ptr_hi));

  a_r3_ptr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 4'd12) |=> !ptr_hi);

  a_r5_master_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 4'd13) |=> (&mask_o) && cmd_o == '0 && sw_req_o == '0 && tc_q == '0 && !ptr_hi);

  a_r6_unmask_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 4'd14) |=> mask_o == '0);

  a_r8_all_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 4'd15) |=> mask_o == $past(wdata_i[NUM_CH-1:0]));

  a_r11_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i == 4'd8 && !(wr_i && idx_i == 4'd13)) |=> tc_q == $past(tc_i));

  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |=> (tc_q & $past(tc_q)) == $past(tc_q));
endmodule

bind dma_regfile dma_regfile_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .idx_i    (idx_i),
  .wdata_i  (wdata_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .ptr_hi   (ptr_hi),
  .tc_i     (tc_i),
  .tc_q     (tc_q),
  .mask_o   (mask_o),
  .sw_req_o (sw_req_o),
  .cmd_o    (cmd_o)
);

// File: tb/dma_regfile_test.sv
`timescale 1ns/1ps
module dma_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  idx = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic [63:0] cur_addr = '0, cur_cnt = '0;
  logic [3:0]  tc = '0, drq = '0;
  logic [63:0] base_addr, base_cnt;
  logic [7:0]  xfer_type, xfer_mode, cmd;
  logic [3:0]  auto_init, addr_dec, mask, sw_req;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dma_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .cur_addr_i(cur_addr), .cur_cnt_i(cur_cnt), .tc_i(tc), .drq_i(drq),
    .base_addr_o(base_addr), .base_cnt_o(base_cnt), .xfer_type_o(xfer_type),
    .auto_init_o(auto_init), .addr_dec_o(addr_dec), .xfer_mode_o(xfer_mode),
    .mask_o(mask), .sw_req_o(sw_req), .cmd_o(cmd)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_port(logic [3:0] a, logic [7:0] d);
    @(negedge clk); idx = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_port(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); idx = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset_state;
    logic [7:0] v;
    check("R13 mask", 64'(mask), 64'hF);
    check("R13 cmd", 64'(cmd), 64'h0);
    check("R13 base_addr", base_addr, 64'h0);
    check("R13 modes", 64'({xfer_mode, xfer_type, auto_init, addr_dec}), 64'h0);
    rd_port(4'd8, v);
    check("R13 status", 64'(v), 64'h0);
    rd_port(4'd13, v);
    check("R13 write-only read", 64'(v), 64'h0);
  endtask

  task automatic t_base_write;
    wr_port(4'd12, 8'h00);
    wr_port(4'd4, 8'h34); wr_port(4'd4, 8'h12);
    check("R1 ch2 addr", 64'(base_addr[47:32]), 64'h1234);
    wr_port(4'd3, 8'hCD); wr_port(4'd3, 8'hAB);
    check("R1 ch1 cnt", 64'(base_cnt[31:16]), 64'hABCD);
  endtask

  task automatic t_ptr_shared;
    logic [7:0] v;
    wr_port(4'd12, 8'h00);
    wr_port(4'd0, 8'h11);
    wr_port(4'd1, 8'h22);
    check("R2 shared pointer", 64'(base_cnt[15:0]), 64'h2200);
    wr_port(4'd12, 8'h00);
    wr_port(4'd0, 8'h55);
    wr_port(4'd11, 8'h00);
    rd_port(4'd8, v);
    wr_port(4'd0, 8'h66);
    check("R2 other ports keep pointer", 64'(base_addr[15:0]), 64'h6655);
  endtask

  task automatic t_ptr_clear;
    wr_port(4'd12, 8'h00);
    wr_port(4'd0, 8'hAA);
    wr_port(4'd12, 8'hFF);
    wr_port(4'd0, 8'h77); wr_port(4'd0, 8'h88);
    check("R3 clear any data", 64'(base_addr[15:0]), 64'h8877);
  endtask

  task automatic t_current_read;
    logic [7:0] lo, hi;
    cur_cnt[63:48]  = 16'hBEEF;
    cur_addr[63:48] = 16'h1357;
    wr_port(4'd12, 8'h00);
    rd_port(4'd7, lo); rd_port(4'd7, hi);
    check("R4 count read", 64'({hi, lo}), 64'hBEEF);
    rd_port(4'd6, lo); rd_port(4'd6, hi);
    check("R4 address read", 64'({hi, lo}), 64'h1357);
    check("R4 base untouched", 64'(base_cnt[63:48]), 64'h0);
    wr_port(4'd7, 8'h01);
    rd_port(4'd7, hi);
    check("R4 write then read high", 64'(hi), 64'hBE);
    check("R4 write to base", 64'(base_cnt[63:48]), 64'h0001);
  endtask

  task automatic t_mode;
    wr_port(4'd11, 8'hB9);
    check("R9 ch1 type", 64'(xfer_type), 64'h08);
    check("R9 ch1 auto/dec", 64'({auto_init, addr_dec}), 64'h22);
    check("R9 ch1 mode", 64'(xfer_mode), 64'h08);
    wr_port(4'd11, 8'hC3);
    check("R9 ch3 cascade, ch1 kept", 64'({xfer_mode, xfer_type}), 64'hC808);
  endtask

  task automatic t_masks;
    wr_port(4'd14, 8'h5A);
    check("R6 unmask all", 64'(mask), 64'h0);
    wr_port(4'd10, 8'h06);
    check("R7 set ch2", 64'(mask), 64'h4);
    wr_port(4'd10, 8'h05);
    check("R7 set ch1", 64'(mask), 64'h6);
    wr_port(4'd10, 8'h02);
    check("R7 clear ch2", 64'(mask), 64'h2);
    wr_port(4'd15, 8'hFA);
    check("R8 all mask", 64'(mask), 64'hA);
  endtask

  task automatic t_req_cmd;
    wr_port(4'd9, 8'h07);
    check("R12 sw req ch3", 64'(sw_req), 64'h8);
    wr_port(4'd9, 8'h06);
    check("R12 sw req ch2", 64'(sw_req), 64'hC);
    wr_port(4'd9, 8'h03);
    check("R12 clear ch3", 64'(sw_req), 64'h4);
    wr_port(4'd8, 8'h5A);
    check("R12 command", 64'(cmd), 64'h5A);
  endtask

  task automatic t_status;
    logic [7:0] v;
    drq = 4'b0001;
    @(negedge clk); tc = 4'b1010;
    @(negedge clk); tc = 4'b0000;
    rd_port(4'd8, v);
    check("R10 status", 64'(v), 64'h5A);
    rd_port(4'd8, v);
    check("R11 cleared by read", 64'(v), 64'h50);
    @(negedge clk); idx = 4'd8; rd = 1'b1; tc = 4'b0001;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0; tc = 4'b0000;
    check("R11 same-cycle pulse hidden", 64'(v), 64'h50);
    rd_port(4'd8, v);
    check("R11 same-cycle pulse kept", 64'(v), 64'h51);
    drq = 4'b0000;
  endtask

  task automatic t_master_reset;
    logic [7:0] v;
    @(negedge clk); tc = 4'b0100;
    @(negedge clk); tc = 4'b0000;
    wr_port(4'd14, 8'h00);
    wr_port(4'd12, 8'h00);
    wr_port(4'd0, 8'h99);
    wr_port(4'd13, 8'h3C);
    check("R5 masks set", 64'(mask), 64'hF);
    check("R5 cmd/req", 64'({cmd, sw_req}), 64'h0);
    check("R5 modes", 64'({xfer_mode, xfer_type, auto_init, addr_dec}), 64'h0);
    rd_port(4'd8, v);
    check("R5 status cleared", 64'(v), 64'h00);
    wr_port(4'd0, 8'h11); wr_port(4'd0, 8'h22);
    check("R5 pointer low", 64'(base_addr[15:0]), 64'h2211);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_base_write();
    t_ptr_shared();
    t_ptr_clear();
    t_current_read();
    t_mode();
    t_masks();
    t_req_cmd();
    t_status();
    t_master_reset();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule